// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Channel

A timer block built around a free-running 16-bit up-counter and two timing channels. Each channel owns a primary general register and a secondary (buffer) register. A channel runs either as an output compare, where the primary register is watched against the counter and a match drives a compare pin and raises a status flag, or as an input capture, where a chosen edge on an external pin copies the counter into the primary register.

With buffering enabled, the secondary register changes role with the mode. In compare mode it holds the next compare value, which is loaded into the primary register on every match, so a software-prepared schedule runs without reprogramming in between. In capture mode it takes the old primary value on each capture, so the two most recent capture times are kept. Software reaches all registers over a simple 16-bit register bus, and a level interrupt request is raised while any flag whose interrupt enable is set stays high.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the counter reads 0, every primary and buffer register reads 0xFFFF, the configuration and status registers read 0, and cmp_o, flag_o and irq_o are all 0.
- R2: The counter increases by one (wrapping 0xFFFF to 0x0000) at each clock edge where cnt_en_i is 1, holds otherwise, and a full-width bus write to address 0 loads it.
- R3: In compare mode, a clock edge where cnt_en_i is 1 and the counter equals the channel's primary register sets the channel's flag, visible from the next cycle.
- R4: The compare pin reacts one clock after the flag is set, with action code (config bits 4:3 of the channel byte) 00 keep, 01 drive 0, 10 drive 1, 11 invert.
- R5: In capture mode (config bit 0 = 1), an edge on cap_i, after a two-stage synchronizer, stores the counter into the primary register and sets the flag; edge code (config bits 2:1) 01 rising, 10 falling, 11 both, 00 none.
- R6: In compare mode with buffering (config bit 5 = 1), each compare match copies the buffer register into the primary register.
- R7: In capture mode with buffering, each capture moves the old primary value into the buffer register while the counter enters the primary register.
- R8: A bus write with bus_be_i other than 2'b11 changes no register.
- R9: A flag bit is cleared by a full write to the status register (address 2, bit n for channel n) with that bit 0, only if the flag was read as 1 beforehand; writing 1 or writing 0 without that read leaves it set.
- R10: If a flag is set by hardware in the same cycle as a valid clear, it stays set.
- R11: irq_o is 1 whenever some channel has its flag set and its interrupt enable (config bit 6) set.
- R12: Address map: 0 counter, 1 configuration (channel n in bits 8n+7:8n, all bits read back), 2 status, 4+n primary of channel n, 6+n buffer of channel n; bus_rdata_o shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Counter advance enable |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (arms flag clearing) |
| bus_be_i | input | 2 | Byte enables; only 2'b11 writes |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of addressed register |
| cap_i | input | 2 | Capture pins, one per channel |
| cmp_o | output | 2 | Compare pins, one per channel |
| flag_o | output | 2 | Channel status flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are a hardware flag set from a compare match and a software clear of the same flag. The bench arms the clear by reading the flag as 1, reloads the counter onto the compare value, then in one cycle both enables counting and writes 0 to the status bit; the flag is judged at the ports right afterwards and must still read 1. The same concern, a hardware update of a register meeting the bus, is covered by the byte-write and buffered-transfer checks.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG = 3'd1;
  localparam logic [ADDR_W-1:0] A_STS = 3'd2;
  localparam int                A_PRI = 4;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  // Per-channel configuration, low 7 bits of the channel byte.
  typedef struct packed {
    logic       irq_en;    // bit 6
    logic       buf_en;    // bit 5
    act_e       act;       // bits 4:3
    logic [1:0] edg;       // bits 2:1
    logic       cap_mode;  // bit 0
  } ch_cfg_t;

  function automatic logic apply_act(act_e a, logic cur);
    logic r;
    case (a)
      ACT_LOW:  r = 1'b0;
      ACT_HIGH: r = 1'b1;
      ACT_TOG:  r = ~cur;
      default:  r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/capcmp_counter.sv
module capcmp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i)        cnt_d = ld_val_i;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: one step per enabled cycle, hold otherwise
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ld_i) |=> $stable(cnt_q));

endmodule

// File: rtl/capcmp_edge.sv
module capcmp_edge #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       evt_o
);

  logic [SYNC_N:0] sh_q, sh_d;
  logic            rise, fall;

  always_comb begin
    sh_d = {sh_q[SYNC_N-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise  = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
  assign fall  = ~sh_q[SYNC_N-1] & sh_q[SYNC_N];
  assign evt_o = (sel_i[0] & rise) | (sel_i[1] & fall);

endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel import capcmp_pkg::*; #(
  parameter int W      = 16,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ch_cfg_t      cfg_i,
  input  logic [W-1:0] cnt_i,
  input  logic         tick_i,
  input  logic         pin_i,
  input  logic         wsel_pri_i,
  input  logic         wsel_buf_i,
  input  logic         wfull_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] pri_o,
  output logic [W-1:0] buf_o,
  output logic         flag_o,
  output logic         out_o,
  output logic         irq_o
);

  logic         cap_evt;
  logic [W-1:0] pri_q, pri_d, buf_q, buf_d;
  logic         flag_q, flag_d, hit_q, hit_d, out_q, out_d;
  logic         cmp_hit, cap_hit, hw_set;

  capcmp_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .sel_i (cfg_i.edg),
    .evt_o (cap_evt)
  );

  always_comb begin
    cmp_hit = !cfg_i.cap_mode && tick_i && (cnt_i == pri_q);
    cap_hit = cfg_i.cap_mode && cap_evt;
    hw_set  = cmp_hit | cap_hit;

    // hardware transfers take priority over the bus
    pri_d = pri_q;
    if (cap_hit)                         pri_d = cnt_i;
    else if (cmp_hit && cfg_i.buf_en)    pri_d = buf_q;
    else if (wsel_pri_i && wfull_i)      pri_d = wdata_i;

    buf_d = buf_q;
    if (cap_hit && cfg_i.buf_en)         buf_d = pri_q;
    else if (wsel_buf_i && wfull_i)      buf_d = wdata_i;

    flag_d = hw_set | (flag_q & ~clr_i);
    hit_d  = cmp_hit;
    out_d  = hit_q ? apply_act(cfg_i.act, out_q) : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= '1;
      buf_q  <= '1;
      flag_q <= 1'b0;
      hit_q  <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      pri_q  <= pri_d;
      buf_q  <= buf_d;
      flag_q <= flag_d;
      hit_q  <= hit_d;
      out_q  <= out_d;
    end
  end

  assign pri_o  = pri_q;
  assign buf_o  = buf_q;
  assign flag_o = flag_q;
  assign out_o  = out_q;
  assign irq_o  = flag_q & cfg_i.irq_en;

  // R3: equality on an enabled edge raises the flag
  p_cmp_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.cap_mode && tick_i && (cnt_i == pri_o)) |=> flag_o);

  // R4: drive-low action lands one clock after the flag
  p_out_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && cfg_i.act == ACT_LOW) |=> !out_o);

  // R6: buffered compare reloads from the buffer
  p_buf_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.cap_mode && cfg_i.buf_en && tick_i && (cnt_i == pri_o))
    |=> (pri_o == $past(buf_o)));

  // R7: buffered capture keeps the previous capture
  p_buf_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.cap_mode && cfg_i.buf_en && cap_evt)
    |=> (buf_o == $past(pri_o) && pri_o == $past(cnt_i)));

  // R8: partial writes leave the primary register alone
  p_byte_ign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel_pri_i && !wfull_i && !hw_set) |=> $stable(pri_o));

  // R10: hardware set beats a simultaneous clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && clr_i) |=> flag_o);

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer import capcmp_pkg::*; #(
  parameter int W      = 16,
  parameter int NCH    = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [W/8-1:0]    bus_be_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic [NCH-1:0]    cap_i,
  output logic [NCH-1:0]    cmp_o,
  output logic [NCH-1:0]    flag_o,
  output logic              irq_o
);

  localparam int CFG_W = 8 * NCH;

  logic             wfull, wr_cnt, wr_cfg, wr_sts, rd_sts;
  logic [W-1:0]     cnt;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [NCH-1:0]   flag, armed_q, armed_d, clr, ch_irq;
  logic [W-1:0]     pri [NCH];
  logic [W-1:0]     bufv [NCH];
  ch_cfg_t          cfg_c [NCH];

  assign wfull  = &bus_be_i;
  assign wr_cnt = bus_wr_i && wfull && (bus_addr_i == A_CNT);
  assign wr_cfg = bus_wr_i && wfull && (bus_addr_i == A_CFG);
  assign wr_sts = bus_wr_i && wfull && (bus_addr_i == A_STS);
  assign rd_sts = bus_rd_i && (bus_addr_i == A_STS);

  capcmp_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (cnt_en_i),
    .ld_i     (wr_cnt),
    .ld_val_i (bus_wdata_i),
    .cnt_o    (cnt)
  );

  always_comb begin
    cfg_d = wr_cfg ? bus_wdata_i[CFG_W-1:0] : cfg_q;
    // a clear is armed by reading the bit as 1 and dropped once the flag is 0
    armed_d = flag & (armed_q | {NCH{rd_sts}});
    clr     = {NCH{wr_sts}} & ~bus_wdata_i[NCH-1:0] & armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      armed_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      armed_q <= armed_d;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] AP = ADDR_W'(A_PRI + ch);
    localparam logic [ADDR_W-1:0] AB = ADDR_W'(A_PRI + NCH + ch);

    assign cfg_c[ch] = ch_cfg_t'(cfg_q[8*ch +: 7]);

    capcmp_channel #(.W(W), .SYNC_N(SYNC_N)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_i      (cfg_c[ch]),
      .cnt_i      (cnt),
      .tick_i     (cnt_en_i),
      .pin_i      (cap_i[ch]),
      .wsel_pri_i (bus_wr_i && (bus_addr_i == AP)),
      .wsel_buf_i (bus_wr_i && (bus_addr_i == AB)),
      .wfull_i    (wfull),
      .wdata_i    (bus_wdata_i),
      .clr_i      (clr[ch]),
      .pri_o      (pri[ch]),
      .buf_o      (bufv[ch]),
      .flag_o     (flag[ch]),
      .out_o      (cmp_o[ch]),
      .irq_o      (ch_irq[ch])
    );

    // R9: a zero written without a prior read leaves the flag set
    p_clr_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && !bus_wdata_i[ch] && !armed_q[ch] && flag[ch]) |=> flag[ch]);
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_CNT)      bus_rdata_o = cnt;
    else if (bus_addr_i == A_CFG) bus_rdata_o = W'(cfg_q);
    else if (bus_addr_i == A_STS) bus_rdata_o = W'(flag);
    for (int ch = 0; ch < NCH; ch++) begin
      if (bus_addr_i == ADDR_W'(A_PRI + ch))       bus_rdata_o = pri[ch];
      if (bus_addr_i == ADDR_W'(A_PRI + NCH + ch)) bus_rdata_o = bufv[ch];
    end
  end

  assign flag_o = flag;
  assign irq_o  = |ch_irq;

endmodule

// File: tb/test_capcmp_timer.sv
`timescale 1ns/1ps
module test_capcmp_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic [2:0]  addr;
  logic        wr, rd;
  logic [1:0]  be;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  cap, cmp, flg;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  capcmp_timer i_capcmp_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cap_i(cap), .cmp_o(cmp), .flag_o(flg), .irq_o(irq)
  );

  function automatic logic act_fn(logic [1:0] a, logic cur);
    case (a)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [7:0] cmp_byte(logic ie, logic bf, logic [1:0] a);
    return {1'b0, ie, bf, a, 3'b000};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bwr(logic [2:0] a, logic [15:0] d, logic [1:0] b = 2'b11);
    addr = a; wdata = d; be = b; wr = 1'b1;
    cyc(1);
    wr = 1'b0; be = 2'b11;
  endtask

  task automatic brd(logic [2:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    cyc(1);
    rd = 1'b0;
  endtask

  task automatic clear_all();
    logic [15:0] t;
    brd(3'd2, t);
    bwr(3'd2, 16'h0000);
  endtask

  task automatic run(int n);
    cnt_en = 1'b1;
    cyc(n);
    cnt_en = 1'b0;
  endtask

  task automatic pulse_cap(int ch, logic v);
    cap[ch] = v;
    cyc(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [1:0]  exp_out;
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; cnt_en = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0;
    be = 2'b11; wdata = '0; cap = '0; exp_out = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    brd(3'd0, v); chk("R1 counter", v, 16'h0000);
    brd(3'd4, v); chk("R1 pri0", v, 16'hFFFF);
    brd(3'd5, v); chk("R1 pri1", v, 16'hFFFF);
    brd(3'd6, v); chk("R1 buf0", v, 16'hFFFF);
    brd(3'd7, v); chk("R1 buf1", v, 16'hFFFF);
    brd(3'd1, v); chk("R1 cfg", v, 16'h0000);
    brd(3'd2, v); chk("R1 status", v, 16'h0000);
    chk("R1 outputs", {13'd0, cmp, irq}, 16'h0000);

    // R2 counting, wrap and hold
    bwr(3'd0, 16'h1234); run(5);
    brd(3'd0, v); chk("R2 count", v, 16'h1239);
    cyc(4);
    brd(3'd0, v); chk("R2 hold", v, 16'h1239);
    bwr(3'd0, 16'hFFFE); run(3);
    brd(3'd0, v); chk("R2 wrap", v, 16'h0001);

    // R12 configuration readback
    bwr(3'd1, 16'hA5C3);
    brd(3'd1, v); chk("R12 cfg readback", v, 16'hA5C3);
    bwr(3'd1, 16'h0101);

    // R8 partial writes
    bwr(3'd4, 16'h1111, 2'b01);
    brd(3'd4, v); chk("R8 low byte ignored", v, 16'hFFFF);
    bwr(3'd7, 16'h2222, 2'b10);
    brd(3'd7, v); chk("R8 high byte ignored", v, 16'hFFFF);
    bwr(3'd0, 16'h3333, 2'b01);
    brd(3'd0, v); chk("R8 counter byte ignored", v, 16'h0001);
    bwr(3'd4, 16'h1111);
    brd(3'd4, v); chk("R12 full write pri0", v, 16'h1111);

    // R3 R4 R6 R11 random compare runs
    for (int it = 0; it < 16; it++) begin
      int          ch = $urandom % 2;
      int          k  = 1 + ($urandom % 20);
      logic        ie = 1'($urandom);
      logic        bf = 1'($urandom);
      logic [1:0]  a  = 2'($urandom);
      logic [15:0] c  = 16'($urandom);
      logic [15:0] b  = 16'($urandom);
      logic [7:0]  cb = cmp_byte(ie, bf, a);
      logic        prev;
      bwr(3'd1, (ch == 0) ? {8'h01, cb} : {cb, 8'h01});
      clear_all();
      bwr(3'd0, c);
      bwr(3'(4 + ch), c + 16'(k));
      bwr(3'(6 + ch), b);
      cnt_en = 1'b1;
      cyc(k);
      chk("R3 no early flag", 16'(flg[ch]), 16'h0);
      cyc(1);
      cnt_en = 1'b0;
      chk("R3 flag on match", 16'(flg[ch]), 16'h1);
      chk("R11 irq follows enable", 16'(irq), 16'(ie));
      prev = exp_out[ch];
      exp_out[ch] = act_fn(a, prev);
      chk("R4 pin waits one clock", 16'(cmp[ch]), 16'(prev));
      brd(3'(4 + ch), v);
      chk("R6 primary after match", v, bf ? b : c + 16'(k));
      chk("R4 pin action", 16'(cmp[ch]), 16'(exp_out[ch]));
    end

    // R5 capture edge selection on channel 1
    bwr(3'd1, 16'h0301);
    clear_all();
    bwr(3'd0, 16'h0A0A);
    pulse_cap(1, 1'b1);
    brd(3'd5, v); chk("R5 rising capture", v, 16'h0A0A);
    chk("R5 capture flag", 16'(flg[1]), 16'h1);
    bwr(3'd0, 16'h0B0B);
    pulse_cap(1, 1'b0);
    brd(3'd5, v); chk("R5 falling ignored in rise mode", v, 16'h0A0A);
    bwr(3'd1, 16'h0501);
    clear_all();
    pulse_cap(1, 1'b1);
    brd(3'd5, v); chk("R5 rising ignored in fall mode", v, 16'h0A0A);
    chk("R5 no flag without edge", 16'(flg[1]), 16'h0);
    pulse_cap(1, 1'b0);
    brd(3'd5, v); chk("R5 falling capture", v, 16'h0B0B);
    bwr(3'd1, 16'h0701);
    bwr(3'd0, 16'h0C0C);
    pulse_cap(1, 1'b1);
    brd(3'd5, v); chk("R5 both edges rise", v, 16'h0C0C);
    bwr(3'd0, 16'h0D0D);
    pulse_cap(1, 1'b0);
    brd(3'd5, v); chk("R5 both edges fall", v, 16'h0D0D);
    bwr(3'd1, 16'h0101);
    bwr(3'd0, 16'h0E0E);
    pulse_cap(1, 1'b1);
    brd(3'd5, v); chk("R5 no edge selected", v, 16'h0D0D);

    // R7 buffered capture on channel 0
    bwr(3'd1, 16'h0723);
    bwr(3'd4, 16'h5555);
    bwr(3'd0, 16'h0100);
    pulse_cap(0, 1'b1);
    brd(3'd4, v); chk("R7 primary gets counter", v, 16'h0100);
    brd(3'd6, v); chk("R7 buffer gets old primary", v, 16'h5555);
    pulse_cap(0, 1'b0);
    bwr(3'd0, 16'h0200);
    pulse_cap(0, 1'b1);
    brd(3'd4, v); chk("R7 second primary", v, 16'h0200);
    brd(3'd6, v); chk("R7 second buffer", v, 16'h0100);
    pulse_cap(1, 1'b0);

    // R9 clear protocol (both flags set here)
    chk("R9 flags set", 16'(flg), 16'h3);
    bwr(3'd2, 16'h0000);
    chk("R9 clear without read", 16'(flg), 16'h3);
    brd(3'd2, v); chk("R9 status read", v, 16'h0003);
    bwr(3'd2, 16'h0002);
    chk("R9 zero clears, one keeps", 16'(flg), 16'h2);

    // R10 set and clear in one cycle on channel 0
    bwr(3'd1, 16'h0140);
    bwr(3'd4, 16'h0300);
    bwr(3'd0, 16'h0300);
    run(1);
    chk("R10 flag from match", 16'(flg[0]), 16'h1);
    brd(3'd2, v);
    bwr(3'd0, 16'h0300);
    addr = 3'd2; wdata = 16'h0000; be = 2'b11; wr = 1'b1; cnt_en = 1'b1;
    cyc(1);
    wr = 1'b0; cnt_en = 1'b0;
    chk("R10 set wins over clear", 16'(flg[0]), 16'h1);
    chk("R11 irq with enable", 16'(irq), 16'h1);
    clear_all();
    chk("R9 clear after read", 16'(flg[0]), 16'h0);
    chk("R11 irq drops", 16'(irq), 16'(flg[1] & 1'b0));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule